// File: doc/BRIEF.md
# Codec Register Command Engine

This block sits on the controller side of a serial audio link and moves codec register accesses through the two command slots of each outgoing frame, and collects the codec's answer from the two status slots of each incoming frame. Software loads a data word, then a command word, into two transmit holding registers. Writing the command word arms the access. On the next frame boundary the armed words are copied into the outgoing slot registers, and the busy flags drop. A read carries no data word, and is marked by one bit in the command word.

On the receive side the engine keeps a status-address holding register and a status-data holding register. Each is captured when the codec marks that slot as valid in its frame tag and the matching receive enable is set. Each has its own valid flag, which a host read clears. The host compares the echoed register index with the one it asked for. A codec number that comes with each command write picks one of four codecs. A command write with a codec number of 4 or more is refused.

Top module: `codec_cmd_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cmd_busy`, `dat_busy`, `addr_valid`, `data_valid`, `slot_cmd_valid` and `slot_dat_valid` are all 0.
- R2: A write with `wr_sel`=1 loads the data holding register and sets `dat_busy`. A write with `wr_sel`=0 loads the command holding register and sets `cmd_busy`. Both flags are visible in the cycle after the write.
- R3: On a `frame_start` cycle with the command armed and `cmd_txen` high, the held command word and its codec number go to `slot_cmd_word` and `slot_codec`, and `slot_cmd_valid` is set. `cmd_busy` reads 0 from the next cycle on, unless a new command is written in that same cycle.
- R4: A loaded data word is sent only together with an armed command. Frame boundaries with no armed command leave `dat_busy` at 1 and `slot_dat_valid` at 0. A read command sent with no data word loaded leaves `slot_dat_valid` at 0.
- R5: While `cmd_txen` is low, an armed command is not sent and `cmd_busy` stays 1. It goes out at the first frame boundary after `cmd_txen` rises.
- R6: While `dat_txen` is low, an armed command is still sent, but the data word is held back and `dat_busy` stays 1.
- R7: A command write while `codec_sel` is 4 or more is ignored: `cmd_busy` stays 0 and nothing is sent at the next frame boundary.
- R8: The slot valid flags and words change only on `frame_start` cycles. A frame boundary with nothing to send clears both valid flags.
- R9: On an `rx_frame` cycle, a status slot is captured and its valid flag set only when both its tag bit and its receive enable are high.
- R10: A read with `rd_en` high and `rd_sel` equal to 0 (address) or 1 (data) returns that holding register on `rd_data` and clears its valid flag. If a capture happens in the same cycle, the capture wins and the flag stays set with the new word.
- R11: A command written on a `frame_start` cycle does not go out in that frame. The frame carries the previously armed word, and the new word stays armed for the next boundary.
- R12: Word layout: the command word holds the register index in bits 18:12 and the read flag in bit 19. The data word holds the 16-bit value in bits 19:4. The engine passes all 20 bits through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at each outgoing frame boundary |
| cmd_txen | input | 1 | Transmit enable for the command slot |
| dat_txen | input | 1 | Transmit enable for the data slot |
| addr_rxen | input | 1 | Receive enable for the status-address slot |
| data_rxen | input | 1 | Receive enable for the status-data slot |
| codec_sel | input | 3 | Codec number for command writes; 4 and above are refused |
| wr_en | input | 1 | Holding-register write strobe |
| wr_sel | input | 1 | 0 selects the command register, 1 the data register |
| wr_data | input | 20 | Word to write |
| rd_en | input | 1 | Receive-register read strobe; clears the valid flag |
| rd_sel | input | 1 | 0 selects status address, 1 status data |
| rd_data | output | 20 | Selected receive holding register |
| cmd_busy | output | 1 | Command word armed, not yet sent |
| dat_busy | output | 1 | Data word loaded, not yet sent |
| addr_valid | output | 1 | Status-address register holds unread data |
| data_valid | output | 1 | Status-data register holds unread data |
| rx_frame | input | 1 | Strobe: incoming status slots are present |
| rx_addr_tag | input | 1 | Frame tag bit for the status-address slot |
| rx_data_tag | input | 1 | Frame tag bit for the status-data slot |
| rx_addr_word | input | 20 | Incoming status-address slot |
| rx_data_word | input | 20 | Incoming status-data slot |
| slot_cmd_valid | output | 1 | Outgoing command slot carries a word this frame |
| slot_cmd_word | output | 20 | Outgoing command slot |
| slot_dat_valid | output | 1 | Outgoing data slot carries a word this frame |
| slot_dat_word | output | 20 | Outgoing data slot |
| slot_codec | output | 2 | Codec addressed by the outgoing command |

## Verification
The main path is tried with a table that mixes writes and reads, several register indices, all four codec numbers and data values with high, low and alternating bits. This separates a lost read flag from a lost index, and shows whether the data slot wrongly goes out for reads. The echo side uses the same table, so a swap of the two receive registers shows up. Directed cases then hold each enable low in turn, write the command on a frame boundary, refuse codec 4, and collide a read with a capture. Each of these tells a correct priority from a plausible wrong one.

// File: rtl/ccmd_pkg.sv
package ccmd_pkg;
    localparam int SLOT_W     = 20;
    localparam int NUM_CODECS = 4;
    localparam int CODEC_W    = $clog2(NUM_CODECS);
    localparam int SEL_W      = CODEC_W + 1;
    localparam int IDX_LSB    = 12;
    localparam int IDX_W      = 7;
    localparam int RD_BIT     = 19;
    localparam int VAL_LSB    = 4;
    localparam int VAL_W      = 16;
    localparam int NUM_RX     = 2;

    typedef enum logic {SEL_CMD = 1'b0, SEL_DAT = 1'b1} wr_target_e;
    typedef enum logic {RX_ADDR = 1'b0, RX_DATA = 1'b1} rx_target_e;

    typedef struct packed {
        logic [SLOT_W-1:0]  word;
        logic [CODEC_W-1:0] codec;
    } cmd_hold_t;

    function automatic logic [SLOT_W-1:0] make_cmd(input logic rd, input logic [IDX_W-1:0] idx);
        logic [SLOT_W-1:0] w;
        w = '0;
        w[IDX_LSB +: IDX_W] = idx;
        w[RD_BIT] = rd;
        return w;
    endfunction

    function automatic logic [SLOT_W-1:0] make_dat(input logic [VAL_W-1:0] v);
        logic [SLOT_W-1:0] w;
        w = '0;
        w[VAL_LSB +: VAL_W] = v;
        return w;
    endfunction
endpackage

// File: rtl/ccmd_tx_stage.sv
module ccmd_tx_stage
    import ccmd_pkg::*;
#(
    parameter int W  = SLOT_W,
    parameter int CW = CODEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          cmd_txen,
    input  logic          dat_txen,
    input  logic          cmd_wr,
    input  logic          dat_wr,
    input  logic [CW-1:0] wr_codec,
    input  logic [W-1:0]  wr_data,
    output logic          cmd_busy,
    output logic          dat_busy,
    output logic          slot_cmd_valid,
    output logic [W-1:0]  slot_cmd_word,
    output logic          slot_dat_valid,
    output logic [W-1:0]  slot_dat_word,
    output logic [CW-1:0] slot_codec
);
    logic [W-1:0]  cmd_q, dat_q;
    logic [CW-1:0] codec_q;
    logic          send_cmd, send_dat;

    assign send_cmd = frame_start && cmd_busy && cmd_txen;
    assign send_dat = send_cmd && dat_busy && dat_txen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_busy       <= 1'b0;
            dat_busy       <= 1'b0;
            cmd_q          <= '0;
            dat_q          <= '0;
            codec_q        <= '0;
            slot_cmd_valid <= 1'b0;
            slot_dat_valid <= 1'b0;
            slot_cmd_word  <= '0;
            slot_dat_word  <= '0;
            slot_codec     <= '0;
        end else begin
            if (frame_start) begin
                slot_cmd_valid <= send_cmd;
                slot_dat_valid <= send_dat;
            end
            if (send_cmd) begin
                slot_cmd_word <= cmd_q;
                slot_codec    <= codec_q;
            end
            if (send_dat) slot_dat_word <= dat_q;

            if (cmd_wr) begin
                cmd_q    <= wr_data;
                codec_q  <= wr_codec;
                cmd_busy <= 1'b1;
            end else if (send_cmd) begin
                cmd_busy <= 1'b0;
            end

            if (dat_wr) begin
                dat_q    <= wr_data;
                dat_busy <= 1'b1;
            end else if (send_dat) begin
                dat_busy <= 1'b0;
            end
        end
    end

    AST_CMD_SENT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cmd_busy && cmd_txen && !cmd_wr) |=> (!cmd_busy && slot_cmd_valid)); // R3
    AST_DAT_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        slot_dat_valid |-> slot_cmd_valid); // R4
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && !cmd_txen) |=> cmd_busy); // R5
    AST_DAT_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (dat_busy && !dat_txen) |=> dat_busy); // R6
    AST_SLOT_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(slot_cmd_valid) && $stable(slot_dat_valid)
                          && $stable(slot_cmd_word))); // R8
endmodule

// File: rtl/ccmd_rx_slot.sv
module ccmd_rx_slot
    import ccmd_pkg::*;
#(
    parameter int W = SLOT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_frame,
    input  logic         tag,
    input  logic         rx_en,
    input  logic [W-1:0] rx_word,
    input  logic         rd_clr,
    output logic         valid,
    output logic [W-1:0] held
);
    logic capture;
    assign capture = rx_frame && tag && rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
        end else if (capture) begin
            valid <= 1'b1;
            held  <= rx_word;
        end else if (rd_clr) begin
            valid <= 1'b0;
        end
    end

    AST_RX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !capture |=> !$rose(valid)); // R9
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !capture) |=> !valid); // R10
    AST_RX_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
        capture |=> (valid && held == $past(rx_word))); // R10
endmodule

// File: rtl/codec_cmd_engine.sv
module codec_cmd_engine
    import ccmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               cmd_txen,
    input  logic               dat_txen,
    input  logic               addr_rxen,
    input  logic               data_rxen,
    input  logic [SEL_W-1:0]   codec_sel,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [SLOT_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [SLOT_W-1:0]  rd_data,
    output logic               cmd_busy,
    output logic               dat_busy,
    output logic               addr_valid,
    output logic               data_valid,
    input  logic               rx_frame,
    input  logic               rx_addr_tag,
    input  logic               rx_data_tag,
    input  logic [SLOT_W-1:0]  rx_addr_word,
    input  logic [SLOT_W-1:0]  rx_data_word,
    output logic               slot_cmd_valid,
    output logic [SLOT_W-1:0]  slot_cmd_word,
    output logic               slot_dat_valid,
    output logic [SLOT_W-1:0]  slot_dat_word,
    output logic [CODEC_W-1:0] slot_codec
);
    logic codec_ok, cmd_wr, dat_wr;
    assign codec_ok = (codec_sel < SEL_W'(NUM_CODECS));
    assign cmd_wr   = wr_en && (wr_target_e'(wr_sel) == SEL_CMD) && codec_ok;
    assign dat_wr   = wr_en && (wr_target_e'(wr_sel) == SEL_DAT);

    ccmd_tx_stage #(.W(SLOT_W), .CW(CODEC_W)) tx_i (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cmd_txen(cmd_txen), .dat_txen(dat_txen),
        .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .wr_codec(codec_sel[CODEC_W-1:0]), .wr_data(wr_data),
        .cmd_busy(cmd_busy), .dat_busy(dat_busy),
        .slot_cmd_valid(slot_cmd_valid), .slot_cmd_word(slot_cmd_word),
        .slot_dat_valid(slot_dat_valid), .slot_dat_word(slot_dat_word),
        .slot_codec(slot_codec)
    );

    logic [NUM_RX-1:0]             rx_tag, rx_en_v, rx_valid;
    logic [NUM_RX-1:0][SLOT_W-1:0] rx_in, rx_held;
    assign rx_tag  = {rx_data_tag, rx_addr_tag};
    assign rx_en_v = {data_rxen, addr_rxen};
    assign rx_in   = {rx_data_word, rx_addr_word};

    for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
        ccmd_rx_slot #(.W(SLOT_W)) slot_i (
            .clk(clk), .rst(rst), .rx_frame(rx_frame),
            .tag(rx_tag[i]), .rx_en(rx_en_v[i]), .rx_word(rx_in[i]),
            .rd_clr(rd_en && (rd_sel == 1'(i))),
            .valid(rx_valid[i]), .held(rx_held[i])
        );
    end

    assign rd_data    = rx_held[rd_sel];
    assign addr_valid = rx_valid[RX_ADDR];
    assign data_valid = rx_valid[RX_DATA];

    AST_BAD_CODEC_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !codec_ok && !cmd_busy) |=> !cmd_busy); // R7
    AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> dat_busy); // R2
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!cmd_busy && !dat_busy && !addr_valid && !data_valid
                 && !slot_cmd_valid && !slot_dat_valid)); // R1
endmodule

// File: tb/codec_cmd_engine_tb.sv
module codec_cmd_engine_tb_top;
    import ccmd_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, frame_start = 1'b0, cmd_txen = 1'b1, dat_txen = 1'b1;
    logic addr_rxen = 1'b1, data_rxen = 1'b1;
    logic [SEL_W-1:0] codec_sel = '0;
    logic wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
    logic [SLOT_W-1:0] wr_data = '0, rx_addr_word = '0, rx_data_word = '0;
    logic rx_frame = 1'b0, rx_addr_tag = 1'b0, rx_data_tag = 1'b0;
    logic [SLOT_W-1:0] rd_data, slot_cmd_word, slot_dat_word;
    logic cmd_busy, dat_busy, addr_valid, data_valid, slot_cmd_valid, slot_dat_valid;
    logic [CODEC_W-1:0] slot_codec;

    codec_cmd_engine dut_i (.*);

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [SLOT_W-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
    endtask

    task automatic rx(input logic ta, input logic td, input logic [SLOT_W-1:0] a, input logic [SLOT_W-1:0] d);
        rx_frame = 1'b1; rx_addr_tag = ta; rx_data_tag = td;
        rx_addr_word = a; rx_data_word = d;
        step();
        rx_frame = 1'b0; rx_addr_tag = 1'b0; rx_data_tag = 1'b0;
    endtask

    // {read flag, index, value, codec}
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 7'h02, 16'h8000, 2'd0},
        {1'b1, 7'h7c, 16'h0000, 2'd1},
        {1'b0, 7'h18, 16'h5a5a, 2'd2},
        {1'b1, 7'h26, 16'h0000, 2'd3},
        {1'b0, 7'h7e, 16'hffff, 2'd3},
        {1'b0, 7'h01, 16'h0001, 2'd1}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk({cmd_busy, dat_busy, addr_valid, data_valid, slot_cmd_valid, slot_dat_valid} == 6'b0,
            "R1 reset flags", {cmd_busy, dat_busy, addr_valid, data_valid, slot_cmd_valid, slot_dat_valid}, 0);
        rst = 1'b0;
        step();

        for (int i = 0; i < NV; i++) begin
            logic rdf; logic [6:0] idx; logic [15:0] val; logic [1:0] cd;
            logic [SLOT_W-1:0] cw, dw;
            {rdf, idx, val, cd} = VEC[i];
            cw = make_cmd(rdf, idx);
            dw = make_dat(val);
            codec_sel = {1'b0, cd};
            if (!rdf) wr(1'b1, dw);
            wr(1'b0, cw);
            chk(cmd_busy && (dat_busy == !rdf), "R2 busy after writes", {cmd_busy, dat_busy}, {1'b1, !rdf});
            frame();
            chk(slot_cmd_valid && slot_cmd_word == cw, "R3 R12 command slot word", slot_cmd_word, cw);
            chk(slot_codec == cd, "R3 codec", slot_codec, cd);
            chk(!cmd_busy && !dat_busy, "R3 busy cleared", {cmd_busy, dat_busy}, 0);
            chk(slot_dat_valid == !rdf, "R4 data slot only for writes", slot_dat_valid, !rdf);
            if (!rdf) chk(slot_dat_word == dw, "R12 data slot word", slot_dat_word, dw);
            step();
            chk(slot_cmd_valid && slot_cmd_word == cw, "R8 slot stable between frames", slot_cmd_word, cw);
            frame();
            chk(!slot_cmd_valid && !slot_dat_valid, "R8 empty frame clears", {slot_cmd_valid, slot_dat_valid}, 0);
            rx(1'b1, 1'b1, cw & ~(20'h1 << RD_BIT), dw);
            chk(addr_valid && data_valid, "R9 capture both", {addr_valid, data_valid}, 2'b11);
            rd_sel = 1'b0; #1;
            chk(rd_data[IDX_LSB +: IDX_W] == idx, "R10 R12 echoed index", rd_data[IDX_LSB +: IDX_W], idx);
            rd_en = 1'b1; step(); rd_en = 1'b0;
            chk(!addr_valid && data_valid, "R10 address read clears only its flag", {addr_valid, data_valid}, 2'b01);
            rd_sel = 1'b1; #1;
            chk(rd_data[VAL_LSB +: VAL_W] == val, "R10 returned value", rd_data[VAL_LSB +: VAL_W], val);
            rd_en = 1'b1; step(); rd_en = 1'b0;
            chk(!data_valid, "R10 data read clears", data_valid, 0);
        end

        // R7: codec number 4 refused
        codec_sel = 3'd4;
        wr(1'b0, make_cmd(1'b0, 7'h10));
        chk(!cmd_busy, "R7 codec 4 refused", cmd_busy, 0);
        frame();
        chk(!slot_cmd_valid, "R7 nothing sent", slot_cmd_valid, 0);
        codec_sel = 3'd2;

        // R4: data alone stays loaded
        wr(1'b1, make_dat(16'h1234));
        frame(); frame();
        chk(dat_busy && !slot_dat_valid, "R4 data waits for command", {dat_busy, slot_dat_valid}, 2'b10);
        wr(1'b0, make_cmd(1'b0, 7'h04));
        frame();
        chk(slot_dat_valid && slot_dat_word == make_dat(16'h1234), "R4 data leaves with command", slot_dat_word, make_dat(16'h1234));

        // R5: command transmit disabled
        cmd_txen = 1'b0;
        wr(1'b0, make_cmd(1'b0, 7'h0a));
        frame();
        chk(cmd_busy && !slot_cmd_valid, "R5 held while disabled", {cmd_busy, slot_cmd_valid}, 2'b10);
        cmd_txen = 1'b1;
        frame();
        chk(!cmd_busy && slot_cmd_word == make_cmd(1'b0, 7'h0a), "R5 sent after enable", slot_cmd_word, make_cmd(1'b0, 7'h0a));

        // R6: data transmit disabled
        dat_txen = 1'b0;
        wr(1'b1, make_dat(16'hbeef));
        wr(1'b0, make_cmd(1'b0, 7'h0c));
        frame();
        chk(slot_cmd_valid && !slot_dat_valid && dat_busy, "R6 command goes, data held",
            {slot_cmd_valid, slot_dat_valid, dat_busy}, 3'b101);
        dat_txen = 1'b1;
        wr(1'b0, make_cmd(1'b0, 7'h0c));
        frame();
        chk(!dat_busy && slot_dat_word == make_dat(16'hbeef), "R6 data sent later", slot_dat_word, make_dat(16'hbeef));

        // R11: command written on a frame boundary
        wr(1'b0, make_cmd(1'b1, 7'h30));
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = make_cmd(1'b1, 7'h32); frame_start = 1'b1;
        step();
        wr_en = 1'b0; frame_start = 1'b0;
        chk(slot_cmd_word == make_cmd(1'b1, 7'h30) && cmd_busy, "R11 frame carries older word",
            slot_cmd_word, make_cmd(1'b1, 7'h30));
        frame();
        chk(slot_cmd_word == make_cmd(1'b1, 7'h32) && !cmd_busy, "R11 newer word next frame",
            slot_cmd_word, make_cmd(1'b1, 7'h32));

        // R9: tag or enable missing
        rx(1'b0, 1'b0, 20'h11111, 20'h22222);
        chk(!addr_valid && !data_valid, "R9 no tag no capture", {addr_valid, data_valid}, 0);
        addr_rxen = 1'b0;
        rx(1'b1, 1'b1, 20'h33333, 20'h44444);
        chk(!addr_valid && data_valid, "R9 receive enable gates", {addr_valid, data_valid}, 2'b01);
        addr_rxen = 1'b1;

        // R10: read colliding with capture
        rd_en = 1'b1; rd_sel = 1'b1;
        rx(1'b0, 1'b1, 20'h0, 20'h55550);
        rd_en = 1'b0; #1;
        chk(data_valid && rd_data == 20'h55550, "R10 capture beats read", rd_data, 20'h55550);

        // R1: reset in the middle of activity
        wr(1'b0, make_cmd(1'b0, 7'h05));
        rst = 1'b1; step(); rst = 1'b0;
        chk({cmd_busy, dat_busy, addr_valid, data_valid, slot_cmd_valid} == 5'b0, "R1 reset clears",
            {cmd_busy, dat_busy, addr_valid, data_valid, slot_cmd_valid}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule